// File: doc/BRIEF.md
# Programmable Nibble Substitution Unit

This block is a 32-bit non-linear substitution datapath. It splits a 32-bit word into eight 4-bit lanes and passes every lane through the same programmable 4-to-4-bit substitution. The substitution is not stored as a lookup table. Each output bit of a lane is the XOR of product terms (monomials) of the lane's input bits, which is its algebraic normal form. The 64 coefficients that select these terms sit in one mask register, and all eight lanes share it.

Software fills the mask serially, a few bits at a time. Each load shifts the mask left and feeds the top bits of a 16-bit load value into the bottom of the mask. Four full-width loads define a complete substitution box. After the mask is programmed, the block accepts one substitution request per cycle. It registers the result, together with a valid flag, one cycle after the request. The current mask is visible on an output so it can be checked.

Top module: `anf_nibble_subst`

## Requirements
- R1: Synchronous active-high reset clears the mask to all zeros, drives the result to 0 and holds the valid flag low.
- R2: A load with count d in 1..15 shifts the mask left by d bits and places bits [15:16-d] of the load value into mask bits [d-1:0], in their original order.
- R3: A load with count 0 shifts the mask left by 16 and places the whole 16-bit load value into mask bits [15:0]. Four such loads replace the whole mask, and the first value loaded ends up in bits [63:48].
- R4: The input word is split into eight lanes: bits [31:28], [27:24], and so on down to [3:0]. Each lane produces the matching output nibble through the same function and does not depend on any other lane.
- R5: Output bit j of a lane is the XOR, over k = 0..15, of mask bit 16*j+k ANDed with the product of the lane input bits that are set in k. Index k = 0 stands for the constant 1.
- R6: A substitution request (sub_en high, load_en low) updates the result and raises the valid flag on the next clock edge.
- R7: In a cycle with no accepted request, the valid flag is low and the result keeps its previous value, whatever the data input does.
- R8: When a load and a substitution request arrive in the same cycle, the load takes effect and the request is dropped: the valid flag stays low and the result is held.
- R9: The mask changes only on a load.
- R10: With an all-zero mask, every accepted request returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Load strobe: shift the mask this cycle |
| load_val | input | 16 | Load value; its top bits are pushed into the mask |
| load_cnt | input | 4 | Number of bits to push; 0 means 16 |
| sub_en | input | 1 | Substitution request |
| sub_in | input | 32 | Word to substitute |
| sub_out | output | 32 | Registered substitution result |
| sub_valid | output | 1 | High for one cycle when sub_out carries a new result |
| mask_out | output | 64 | Current coefficient mask |

## Verification
The bound checker watches several rules on every cycle:
- the valid flag follows accepted requests and drops when a load collides with a request;
- the result holds between accepted requests;
- the mask stays frozen without a load;
- one-bit and sixteen-bit shifts behave as stated;
- reset clears the state;
- an all-zero mask yields a zero result.

Some behaviours only the bench scenarios can show:
- a real cipher S-box, converted to its algebraic-normal-form coefficients, reproduces its table for all 16 values in every lane;
- shifts of uneven widths land in the right place;
- single-monomial masks isolate the constant and product terms.

// File: rtl/anf_pkg.sv
package anf_pkg;
  localparam int LANE_W  = 4;
  localparam int LANES   = 8;
  localparam int LOAD_W  = 16;
  localparam int CNT_W   = 4;
  localparam int TERMS   = 2 ** LANE_W;
  localparam int MASK_W  = TERMS * LANE_W;
  localparam int DATA_W  = LANES * LANE_W;
endpackage

// File: rtl/anf_mask_reg.sv
module anf_mask_reg #(
  parameter int MASK_W = 64,
  parameter int LOAD_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [LOAD_W-1:0] load_val,
  input  logic [CNT_W-1:0]  load_cnt,
  output logic [MASK_W-1:0] mask
);
  localparam int AMT_W = $clog2(LOAD_W + 1);
  localparam int CAT_W = MASK_W + LOAD_W;

  logic [AMT_W-1:0]  amt;
  logic [CAT_W-1:0]  cat;
  logic [MASK_W-1:0] mask_nxt;

  // a zero count is the full-width push
  always_comb begin
    if (load_cnt == '0) amt = AMT_W'(LOAD_W);
    else                amt = AMT_W'(load_cnt);
    cat      = {mask, load_val} << amt;
    mask_nxt = cat[CAT_W-1:LOAD_W];
  end

  always_ff @(posedge clk) begin
    if (rst)          mask <= '0;
    else if (load_en) mask <= mask_nxt;
  end
endmodule

// File: rtl/anf_lane.sv
module anf_lane #(
  parameter int W = 4
) (
  input  logic [W-1:0]          x,
  input  logic [(2**W)*W-1:0]   coef,
  output logic [W-1:0]          y
);
  localparam int TERMS = 2 ** W;

  logic [TERMS-1:0] mono;

  // monomial k: product of the input bits that are set in k (k=0 gives 1)
  for (genvar k = 0; k < TERMS; k++) begin : g_mono
    localparam logic [W-1:0] SEL = W'(k);
    assign mono[k] = &(x | ~SEL);
  end

  for (genvar j = 0; j < W; j++) begin : g_bit
    assign y[j] = ^(coef[j*TERMS +: TERMS] & mono);
  end
endmodule

// File: rtl/anf_nibble_subst.sv
module anf_nibble_subst
  import anf_pkg::*;
#(
  parameter int P_LANE_W = LANE_W,
  parameter int P_LANES  = LANES,
  parameter int P_LOAD_W = LOAD_W,
  parameter int P_CNT_W  = CNT_W,
  localparam int P_MASK_W = (2 ** P_LANE_W) * P_LANE_W,
  localparam int P_DATA_W = P_LANES * P_LANE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_en,
  input  logic [P_LOAD_W-1:0] load_val,
  input  logic [P_CNT_W-1:0]  load_cnt,
  input  logic                sub_en,
  input  logic [P_DATA_W-1:0] sub_in,
  output logic [P_DATA_W-1:0] sub_out,
  output logic                sub_valid,
  output logic [P_MASK_W-1:0] mask_out
);
  logic [P_MASK_W-1:0] mask;
  logic [P_DATA_W-1:0] lane_y;
  logic                accept;

  anf_mask_reg #(
    .MASK_W(P_MASK_W),
    .LOAD_W(P_LOAD_W),
    .CNT_W (P_CNT_W)
  ) u_mask (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .load_val(load_val),
    .load_cnt(load_cnt),
    .mask    (mask)
  );

  for (genvar i = 0; i < P_LANES; i++) begin : g_lane
    anf_lane #(.W(P_LANE_W)) u_lane (
      .x   (sub_in[i*P_LANE_W +: P_LANE_W]),
      .coef(mask),
      .y   (lane_y[i*P_LANE_W +: P_LANE_W])
    );
  end

  // a load in the same cycle wins; the request is dropped
  assign accept = sub_en & ~load_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_out   <= '0;
      sub_valid <= 1'b0;
    end else begin
      sub_valid <= accept;
      if (accept) sub_out <= lane_y;
    end
  end

  assign mask_out = mask;
endmodule

// File: rtl/anf_nibble_subst_chk.sv
module anf_nibble_subst_chk #(
  parameter int MASK_W = 64,
  parameter int DATA_W = 32,
  parameter int LOAD_W = 16,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              load_en,
  input logic [LOAD_W-1:0] load_val,
  input logic [CNT_W-1:0]  load_cnt,
  input logic              sub_en,
  input logic [DATA_W-1:0] sub_out,
  input logic              sub_valid,
  input logic [MASK_W-1:0] mask_out
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (mask_out == '0 && !sub_valid && sub_out == '0));

  assert_shift_one_R2: assert property (@(posedge clk) disable iff (rst)
    (load_en && load_cnt == CNT_W'(1)) |=>
      mask_out == {$past(mask_out[MASK_W-2:0]), $past(load_val[LOAD_W-1])});

  assert_shift_full_R3: assert property (@(posedge clk) disable iff (rst)
    (load_en && load_cnt == '0) |=>
      mask_out == {$past(mask_out[MASK_W-LOAD_W-1:0]), $past(load_val)});

  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (rst)
    (sub_en && !load_en) |=> sub_valid);

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !sub_valid |-> $stable(sub_out));

  assert_load_wins_R8: assert property (@(posedge clk) disable iff (rst)
    load_en |=> !sub_valid);

  assert_mask_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(mask_out));

  assert_zero_mask_R10: assert property (@(posedge clk) disable iff (rst)
    (mask_out == '0 && sub_en && !load_en) |=> sub_out == '0);
endmodule

bind anf_nibble_subst anf_nibble_subst_chk #(
  .MASK_W(P_MASK_W),
  .DATA_W(P_DATA_W),
  .LOAD_W(P_LOAD_W),
  .CNT_W (P_CNT_W)
) u_chk (.*);

// File: tb/anf_nibble_subst_test.sv
`timescale 1ns/1ps
module anf_nibble_subst_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_en = 1'b0;
  logic [15:0] load_val = '0;
  logic [3:0]  load_cnt = '0;
  logic        sub_en = 1'b0;
  logic [31:0] sub_in = '0;
  logic [31:0] sub_out;
  logic        sub_valid;
  logic [63:0] mask_out;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  anf_nibble_subst uut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_val(load_val),
    .load_cnt(load_cnt), .sub_en(sub_en), .sub_in(sub_in),
    .sub_out(sub_out), .sub_valid(sub_valid), .mask_out(mask_out)
  );

  localparam logic [3:0] SBOX [16] = '{4'hC, 4'h5, 4'h6, 4'hB, 4'h9, 4'h0, 4'hA, 4'hD,
                                       4'h3, 4'hE, 4'hF, 4'h8, 4'h4, 4'h7, 4'h1, 4'h2};
  localparam logic [31:0] VEC_IN [8] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0123_4567,
                                         32'h89AB_CDEF, 32'hDEAD_BEEF, 32'h1357_9BDF,
                                         32'hF0E1_D2C3, 32'h5A5A_A5A5};

  function automatic logic [31:0] ref_sub(input logic [31:0] w);
    logic [31:0] r;
    for (int i = 0; i < 8; i++) r[4*i +: 4] = SBOX[w[4*i +: 4]];
    return r;
  endfunction

  // algebraic normal form coefficients of the table, one 16-bit slice per output bit
  function automatic logic [63:0] anf_coef();
    logic [63:0] c;
    logic [15:0] f;
    for (int j = 0; j < 4; j++) begin
      for (int k = 0; k < 16; k++) f[k] = SBOX[k][j];
      for (int i = 0; i < 4; i++)
        for (int k = 0; k < 16; k++)
          if (k[i]) f[k] = f[k] ^ f[k ^ (1 << i)];
      c[16*j +: 16] = f;
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [15:0] v, input logic [3:0] c);
    @(negedge clk);
    load_en = 1'b1; load_val = v; load_cnt = c;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic do_sub(input logic [31:0] w);
    @(negedge clk);
    sub_en = 1'b1; sub_in = w;
    @(negedge clk);
    sub_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    logic [63:0] coef;
    logic [31:0] held;
    coef = anf_coef();

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 mask", mask_out, 64'h0);
    chk("R1 out", {32'h0, sub_out}, 64'h0);
    chk("R1 valid", {63'h0, sub_valid}, 64'h0);

    // R10 zero mask gives zero
    do_sub(32'hDEAD_BEEF);
    chk("R10 zero mask", {32'h0, sub_out}, 64'h0);
    chk("R6 valid", {63'h0, sub_valid}, 64'h1);

    // R2 partial pushes
    do_load(16'hA000, 4'd3);
    chk("R2 cnt3", mask_out, 64'h5);
    do_load(16'hFFFF, 4'd1);
    chk("R2 cnt1", mask_out, 64'hB);
    do_load(16'h1234, 4'd0);
    chk("R3 cnt0", mask_out, 64'hB_1234);
    do_load(16'hC000, 4'd15);
    chk("R2 cnt15", mask_out, 64'h5_891A_6000);

    // R5 constant term only: every lane yields 0001
    do_reset();
    do_load(16'h8000, 4'd1);
    do_sub(32'h3F01_2357);
    chk("R5 constant", {32'h0, sub_out}, 64'h1111_1111);
    // R5 monomial x0*x1 on output bit 1 (mask bit 19)
    do_load(16'h0000, 4'd0);
    do_load(16'h0000, 4'd3);
    chk("R2 mask19", mask_out, 64'h8_0000);
    do_sub(32'h3F01_2357);
    chk("R5 x0x1", {32'h0, sub_out}, 64'h2200_0202);

    // R3 full program with four loads, first value on top
    for (int q = 3; q >= 0; q--) do_load(coef[16*q +: 16], 4'd0);
    chk("R3 full mask", mask_out, coef);

    // R4 vector table
    for (int v = 0; v < 8; v++) begin
      do_sub(VEC_IN[v]);
      chk("R4 table", {32'h0, sub_out}, {32'h0, ref_sub(VEC_IN[v])});
    end
    // R4/R5 all 16 values on every lane
    for (int v = 0; v < 16; v++) begin
      logic [31:0] w;
      for (int i = 0; i < 8; i++) w[4*i +: 4] = 4'((v + i) & 15);
      do_sub(w);
      chk("R4 sweep", {32'h0, sub_out}, {32'h0, ref_sub(w)});
    end

    // R7 hold while idle with changing input
    held = sub_out;
    @(negedge clk); sub_in = 32'h1234_5678;
    @(negedge clk); sub_in = 32'h8765_4321;
    @(negedge clk);
    chk("R7 hold", {32'h0, sub_out}, {32'h0, held});
    chk("R7 valid low", {63'h0, sub_valid}, 64'h0);
    chk("R9 mask frozen", mask_out, coef);

    // R8 collision: load wins, request dropped
    @(negedge clk);
    load_en = 1'b1; load_val = 16'hFFFF; load_cnt = 4'd4;
    sub_en = 1'b1; sub_in = 32'h0000_0000;
    @(negedge clk);
    load_en = 1'b0; sub_en = 1'b0;
    chk("R8 valid low", {63'h0, sub_valid}, 64'h0);
    chk("R8 out held", {32'h0, sub_out}, {32'h0, held});
    chk("R8 mask loaded", mask_out, {coef[59:0], 4'hF});

    // R1 reset mid-run
    do_reset();
    chk("R1 mask again", mask_out, 64'h0);
    chk("R1 out again", {32'h0, sub_out}, 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule